// File: doc/BRIEF.md
# Decimal Thumbwheel to Synthesizer Tuning Word Loader

This block turns a carrier frequency, set on five decimal thumbwheel digits, into the 48-bit phase increment that a direct digital synthesizer needs. It then delivers that increment to the synthesizer over a three-wire serial write path. The synthesizer runs from a 50 MHz system clock and has to produce four times the selected carrier. The increment is therefore floor(4 · f · 2^48 / 50 MHz), where f is the dialled carrier frequency.

A load runs once after chip reset. It runs again whenever the active-low load request input is pulled low. At the start of a load the digits are captured. They are converted to binary one digit per cycle, scaled by shift-and-add, and divided by restoring division. None of these steps uses wide combinational arithmetic. The result goes out as six byte writes. Each write is framed by a write-enable strobe, and the serial clock runs only inside a frame. A one-cycle done pulse closes the sequence. A digit outside 0..9 stops the load and raises an error flag.

Top module: `ftw_loader`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, sclk_o, we_o, done_o and err_o are all low. With no other stimulus, a load of the digits present at release runs to completion.
- R2: digits_i holds five BCD digits in units of 100 Hz, and bits [19:16] are the most significant digit. The carrier is f = (decimal value) × 100 Hz.
- R3: The word sent is floor(4 × f × 2^48 / 50,000,000), truncated to 48 bits.
- R4: Each load sends exactly six byte frames. Bytes go most significant first, and bits within a byte go MSB first.
- R5: sclk_o idles low and pulses only while we_o is high. Each frame carries exactly eight rising edges.
- R6: sdo_o changes only while sclk_o is low. The receiver samples it on the rising edge of sclk_o.
- R7: done_o goes high for exactly one cycle, after the sixth frame has ended, and once per completed load.
- R8: A digit nibble above 9 stops the load. err_o then stays high, no frame is sent and done_o does not pulse. The next load start clears err_o.
- R9: A falling edge on load_req_ni, taken through a two-stage synchronizer, starts a new load with the digits present at that time.
- R10: A load request that arrives during a load aborts it. The frame in flight is cut short, the aborted load gives no done pulse, and a full six-frame sequence for the newly captured digits follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset; a load follows its release |
| load_req_ni | input | 1 | Active-low load request, asynchronous |
| digits_i | input | 20 | Five BCD digits, most significant in the top nibble |
| sclk_o | output | 1 | Gated serial clock |
| sdo_o | output | 1 | Serial data, MSB first |
| we_o | output | 1 | Write strobe, high for each byte frame |
| done_o | output | 1 | One-cycle pulse after the sixth byte |
| err_o | output | 1 | Invalid digit seen on the last load |

## Verification
The hardest case to reach from the ports is a restart that lands inside a byte frame. The old frame must be truncated, the aborted load must give no done pulse, and the new stream must carry only the new word. To reach it, the bench waits for the rising strobe of the second frame, changes the digits and drops the request at that moment, so the abort hits while the serializer is mid-byte. The bench then rebuilds the received bytes from the rising serial clock edges. It keeps only complete eight-bit frames and compares the six-byte result against a word computed with wide integer arithmetic. It does the same for a sweep of every value in every digit position.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef enum logic [1:0] {TOP_IDLE, TOP_CONV, TOP_CALC, TOP_SEND} top_st_e;
    typedef enum logic [1:0] {CALC_IDLE, CALC_MUL, CALC_DIV} calc_st_e;
    typedef enum logic [1:0] {SER_IDLE, SER_LOW, SER_HIGH} ser_st_e;
endpackage

// File: rtl/fl_bcd2bin.sv
module fl_bcd2bin #(
    parameter int DIGITS = 5,
    parameter int BIN_W  = 17
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [4*DIGITS-1:0]   digits_i,
    output logic [BIN_W-1:0]      bin_o,
    output logic                  done_o,
    output logic                  err_o
);
    localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    typedef struct packed {
        logic                run;
        logic [IDX_W-1:0]    idx;
        logic [4*DIGITS-1:0] sh;
        logic [BIN_W-1:0]    acc;
        logic                done;
        logic                err;
    } st_t;

    st_t s_d, s_q;
    logic [3:0]       nib;
    logic [BIN_W-1:0] times10;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        nib      = s_q.sh[4*DIGITS-1 -: 4];
        times10  = (s_q.acc << 3) + (s_q.acc << 1);
        if (start_i) begin
            s_d.run = 1'b1;
            s_d.idx = '0;
            s_d.sh  = digits_i;
            s_d.acc = '0;
        end else if (s_q.run) begin
            if (nib > 4'd9) begin
                s_d.run = 1'b0;
                s_d.err = 1'b1;
            end else begin
                s_d.acc = times10 + BIN_W'(nib);
                s_d.sh  = s_q.sh << 4;
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == IDX_W'(DIGITS - 1)) begin
                    s_d.run  = 1'b0;
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign bin_o  = s_q.acc;
    assign done_o = s_q.done;
    assign err_o  = s_q.err;
endmodule

// File: rtl/fl_ftw_calc.sv
module fl_ftw_calc
    import fl_pkg::*;
#(
    parameter int BIN_W     = 17,
    parameter int SCALE     = 400,
    parameter int SYSCLK_HZ = 50_000_000,
    parameter int FTW_W     = 48
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic [BIN_W-1:0]  bin_i,
    output logic [FTW_W-1:0]  ftw_o,
    output logic              done_o
);
    localparam int SCALE_W = $clog2(SCALE + 1);
    localparam int PROD_W  = BIN_W + SCALE_W;
    localparam int REM_W   = $clog2(SYSCLK_HZ) + 1;
    localparam int CNT_MAX = (FTW_W > SCALE_W) ? FTW_W : SCALE_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [REM_W:0] DIVISOR = (REM_W + 1)'(SYSCLK_HZ);

    typedef struct packed {
        calc_st_e           st;
        logic [CNT_W-1:0]   cnt;
        logic [PROD_W-1:0]  mcand;
        logic [SCALE_W-1:0] mier;
        logic [PROD_W-1:0]  prod;
        logic [REM_W-1:0]   rem;
        logic [FTW_W-1:0]   q;
        logic               done;
    } st_t;

    st_t s_d, s_q;
    logic [PROD_W-1:0] prod_nx;
    logic [REM_W:0]    rem2;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        prod_nx  = s_q.prod + (s_q.mier[0] ? s_q.mcand : '0);
        rem2     = {s_q.rem, 1'b0};
        if (clr_i) begin
            s_d.st = CALC_IDLE;
        end else if (start_i) begin
            s_d.st    = CALC_MUL;
            s_d.cnt   = '0;
            s_d.mcand = PROD_W'(bin_i);
            s_d.mier  = SCALE_W'(SCALE);
            s_d.prod  = '0;
        end else begin
            unique case (s_q.st)
                CALC_MUL: begin
                    s_d.prod  = prod_nx;
                    s_d.mcand = s_q.mcand << 1;
                    s_d.mier  = s_q.mier >> 1;
                    s_d.cnt   = s_q.cnt + 1'b1;
                    if (s_q.cnt == CNT_W'(SCALE_W - 1)) begin
                        s_d.st  = CALC_DIV;
                        s_d.cnt = '0;
                        s_d.rem = REM_W'(prod_nx);
                        s_d.q   = '0;
                    end
                end
                CALC_DIV: begin
                    if (rem2 >= DIVISOR) begin
                        s_d.rem = REM_W'(rem2 - DIVISOR);
                        s_d.q   = {s_q.q[FTW_W-2:0], 1'b1};
                    end else begin
                        s_d.rem = REM_W'(rem2);
                        s_d.q   = {s_q.q[FTW_W-2:0], 1'b0};
                    end
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == CNT_W'(FTW_W - 1)) begin
                        s_d.st   = CALC_IDLE;
                        s_d.done = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign ftw_o  = s_q.q;
    assign done_o = s_q.done;
endmodule

// File: rtl/fl_byte_ser.sv
module fl_byte_ser
    import fl_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HALF   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              we_o,
    output logic              done_o
);
    localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(BYTE_W);

    typedef struct packed {
        ser_st_e           st;
        logic [HC_W-1:0]   hc;
        logic [BIT_W-1:0]  bitn;
        logic [BYTE_W-1:0] sh;
        logic              sclk;
        logic              sdo;
        logic              we;
        logic              done;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (clr_i) begin
            s_d.st   = SER_IDLE;
            s_d.sclk = 1'b0;
            s_d.we   = 1'b0;
        end else if (start_i) begin
            s_d.st   = SER_LOW;
            s_d.hc   = '0;
            s_d.bitn = '0;
            s_d.sh   = byte_i;
            s_d.sdo  = byte_i[BYTE_W-1];
            s_d.we   = 1'b1;
            s_d.sclk = 1'b0;
        end else begin
            unique case (s_q.st)
                SER_LOW: begin
                    if (s_q.hc == HC_W'(HALF - 1)) begin
                        s_d.st   = SER_HIGH;
                        s_d.hc   = '0;
                        s_d.sclk = 1'b1;
                    end else begin
                        s_d.hc = s_q.hc + 1'b1;
                    end
                end
                SER_HIGH: begin
                    if (s_q.hc == HC_W'(HALF - 1)) begin
                        s_d.hc   = '0;
                        s_d.sclk = 1'b0;
                        if (s_q.bitn == BIT_W'(BYTE_W - 1)) begin
                            s_d.st   = SER_IDLE;
                            s_d.we   = 1'b0;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.st   = SER_LOW;
                            s_d.bitn = s_q.bitn + 1'b1;
                            s_d.sh   = s_q.sh << 1;
                            s_d.sdo  = s_q.sh[BYTE_W-2];
                        end
                    end else begin
                        s_d.hc = s_q.hc + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sclk_o = s_q.sclk;
    assign sdo_o  = s_q.sdo;
    assign we_o   = s_q.we;
    assign done_o = s_q.done;
endmodule

// File: rtl/ftw_loader.sv
module ftw_loader
    import fl_pkg::*;
#(
    parameter int DIGITS       = 5,
    parameter int FTW_W        = 48,
    parameter int BYTE_W       = 8,
    parameter int SYSCLK_HZ    = 50_000_000,
    parameter int STEP_HZ      = 100,
    parameter int CARRIER_MULT = 4,
    parameter int SCLK_HALF    = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_req_ni,
    input  logic [4*DIGITS-1:0] digits_i,
    output logic                sclk_o,
    output logic                sdo_o,
    output logic                we_o,
    output logic                done_o,
    output logic                err_o
);
    localparam int BYTES = FTW_W / BYTE_W;
    localparam int BIN_W = $clog2(10 ** DIGITS);
    localparam int SCALE = STEP_HZ * CARRIER_MULT;
    localparam int BI_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   boot;
        top_st_e                st;
        logic [BI_W-1:0]        bidx;
        logic                   go;
        logic                   done;
        logic                   err;
    } st_t;

    st_t s_d, s_q;

    logic              trig;
    logic              calc_start;
    logic              conv_done, conv_err, calc_done, ser_done;
    logic [BIN_W-1:0]  bin;
    logic [FTW_W-1:0]  ftw;
    logic [BI_W-1:0]   sel;
    logic [BYTE_W-1:0] tx_byte;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.go     = 1'b0;
        s_d.sync   = {s_q.sync[SYNC_STAGES-2:0], load_req_ni};
        s_d.prev   = s_q.sync[SYNC_STAGES-1];
        trig       = s_q.boot | (s_q.prev & ~s_q.sync[SYNC_STAGES-1]);
        calc_start = 1'b0;
        sel        = BI_W'(BYTES - 1) - s_q.bidx;
        tx_byte    = ftw[int'(sel)*BYTE_W +: BYTE_W];
        if (trig) begin
            s_d.st   = TOP_CONV;
            s_d.boot = 1'b0;
            s_d.err  = 1'b0;
        end else begin
            unique case (s_q.st)
                TOP_CONV: begin
                    if (conv_err) begin
                        s_d.st  = TOP_IDLE;
                        s_d.err = 1'b1;
                    end else if (conv_done) begin
                        s_d.st     = TOP_CALC;
                        calc_start = 1'b1;
                    end
                end
                TOP_CALC: begin
                    if (calc_done) begin
                        s_d.st   = TOP_SEND;
                        s_d.bidx = '0;
                        s_d.go   = 1'b1;
                    end
                end
                TOP_SEND: begin
                    if (ser_done) begin
                        if (s_q.bidx == BI_W'(BYTES - 1)) begin
                            s_d.st   = TOP_IDLE;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.bidx = s_q.bidx + 1'b1;
                            s_d.go   = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q      <= '0;
            s_q.sync <= '1;
            s_q.prev <= 1'b1;
            s_q.boot <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    fl_bcd2bin #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_conv (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (trig),
        .digits_i(digits_i),
        .bin_o   (bin),
        .done_o  (conv_done),
        .err_o   (conv_err)
    );

    fl_ftw_calc #(
        .BIN_W(BIN_W), .SCALE(SCALE), .SYSCLK_HZ(SYSCLK_HZ), .FTW_W(FTW_W)
    ) u_calc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (trig),
        .start_i(calc_start),
        .bin_i  (bin),
        .ftw_o  (ftw),
        .done_o (calc_done)
    );

    fl_byte_ser #(.BYTE_W(BYTE_W), .HALF(SCLK_HALF)) u_ser (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (trig),
        .start_i(s_q.go),
        .byte_i (tx_byte),
        .sclk_o (sclk_o),
        .sdo_o  (sdo_o),
        .we_o   (we_o),
        .done_o (ser_done)
    );

    assign done_o = s_q.done;
    assign err_o  = s_q.err;
endmodule

// File: rtl/ftw_loader_chk.sv
module ftw_loader_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic sclk_o,
    input logic sdo_o,
    input logic we_o,
    input logic done_o,
    input logic err_o
);
    AST_SCLK_FRAMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> we_o); // R5

    AST_SDO_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> $stable(sdo_o)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7

    AST_DONE_OUTSIDE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !we_o); // R7

    AST_ERR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (!we_o && !done_o)); // R8
endmodule

bind ftw_loader ftw_loader_chk u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sclk_o(sclk_o),
    .sdo_o (sdo_o),
    .we_o  (we_o),
    .done_o(done_o),
    .err_o (err_o)
);

// File: tb/ftw_loader_bench.sv
`timescale 1ns/1ps
module ftw_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_n = 1'b1;
    logic [19:0] digits = 20'h12345;
    logic        sclk, sdo, we, done, err;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mon_sh = '0;
    int         mon_bits = 0;
    logic [7:0] cap [0:15];
    int         ncap = 0;
    int         done_cnt = 0;
    int         bad_sclk = 0;

    always #2.5 clk = ~clk;

    ftw_loader u_ftw_loader (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .load_req_ni(req_n),
        .digits_i   (digits),
        .sclk_o     (sclk),
        .sdo_o      (sdo),
        .we_o       (we),
        .done_o     (done),
        .err_o      (err)
    );

    always @(posedge sclk) begin
        if (!we) bad_sclk++;
        mon_sh = {mon_sh[6:0], sdo};
        mon_bits++;
    end
    always @(posedge we) mon_bits = 0;
    always @(negedge we) begin
        if (mon_bits == 8 && ncap < 16) begin
            cap[ncap] = mon_sh;
            ncap++;
        end
    end
    always @(negedge clk) if (done) done_cnt++;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_ftw(input logic [19:0] d);
        logic [95:0] v;
        logic [95:0] n;
        v = '0;
        for (int i = 4; i >= 0; i--) v = v * 10 + 96'(d[4*i +: 4]);
        n = (v * 400) << 48;
        n = n / 96'd50000000;
        return n[47:0];
    endfunction

    task automatic clear_mon();
        ncap = 0;
        done_cnt = 0;
        bad_sclk = 0;
    endtask

    task automatic pulse_req();
        @(negedge clk) req_n = 1'b0;
        repeat (3) @(negedge clk);
        req_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (done_cnt > 0) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_stream(input logic [19:0] d, input string req);
        logic [47:0] got;
        logic [47:0] exp;
        exp = exp_ftw(d);
        got = '0;
        for (int k = 0; k < 6; k++) got = {got[39:0], cap[k]};
        check(ncap == 6, {req, " R4 frame count"}, 64'(ncap), 64'd6);
        check(got == exp, {req, " R3 R4 R6 word"}, 64'(got), 64'(exp));
        check(done_cnt == 1, {req, " R7 done pulses"}, 64'(done_cnt), 64'd1);
        check(bad_sclk == 0, {req, " R5 sclk outside frame"}, 64'(bad_sclk), 64'd0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [19:0] dg;
        repeat (4) @(negedge clk);
        check(!sclk && !we && !done && !err, "R1 R5 outputs in reset",
              64'({sclk, we, done, err}), 64'd0);
        clear_mon();
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk && !we && !done && !err, "R1 outputs after release",
              64'({sclk, we, done, err}), 64'd0);
        wait_done();
        check_stream(20'h12345, "R1 power-up load");

        // R2 R9: every value in every digit position
        for (int pos = 0; pos < 5; pos++) begin
            for (int d = 0; d < 10; d++) begin
                dg = 20'h31415;
                dg[4*pos +: 4] = 4'(d);
                digits = dg;
                clear_mon();
                pulse_req();
                wait_done();
                check_stream(dg, "R2 R9 sweep");
            end
        end
        digits = 20'h00000; clear_mon(); pulse_req(); wait_done();
        check_stream(20'h00000, "R2 zero");
        digits = 20'h99999; clear_mon(); pulse_req(); wait_done();
        check_stream(20'h99999, "R2 R3 maximum");
        digits = 20'h00001; clear_mon(); pulse_req(); wait_done();
        check_stream(20'h00001, "R3 one step");

        // R8: invalid digits
        digits = 20'h12A45; clear_mon(); pulse_req();
        repeat (600) @(negedge clk);
        check(err == 1'b1, "R8 err raised", 64'(err), 64'd1);
        check(ncap == 0 && done_cnt == 0, "R8 no frames",
              64'(ncap + done_cnt), 64'd0);
        digits = 20'hF0000; clear_mon(); pulse_req();
        repeat (600) @(negedge clk);
        check(err == 1'b1 && ncap == 0 && done_cnt == 0, "R8 top digit invalid",
              64'({err, 8'(ncap)}), 64'h100);
        digits = 20'h04200; clear_mon(); pulse_req();
        repeat (10) @(negedge clk);
        check(err == 1'b0, "R8 err cleared on new load", 64'(err), 64'd0);
        wait_done();
        check_stream(20'h04200, "R8 recovery load");

        // R10: restart inside the second frame
        digits = 20'h55555; clear_mon(); pulse_req();
        for (int i = 0; i < 3000; i++) begin
            if (ncap >= 1 && we) break;
            @(negedge clk);
        end
        digits = 20'h07321;
        clear_mon();
        pulse_req();
        wait_done();
        check_stream(20'h07321, "R10 restart mid-frame");
        repeat (400) @(negedge clk);
        check(done_cnt == 1, "R10 no extra done", 64'(done_cnt), 64'd1);

        finish_run();
    end
endmodule